// File: doc/BRIEF.md
# Up/Down Timer with Buffered Period and Compare

This block is a 16-bit timer/counter that advances only on cycles where a prescaled tick enable is high. A direction input chooses between incrementing and decrementing. When counting up, the count wraps to zero after it reaches the active period and raises an overflow pulse. When counting down, the count wraps from zero back to the period and raises an underflow pulse. In one-shot mode the counter halts at the first such wrap.

The period and a set of compare values each have a buffer that can be written at any time. A buffer only reaches its active register on an update. A hardware update happens at every wrap, unless the lock input holds it off. Software commands are latched when written and carried out on the next tick: restart, halt, forced buffer copy, and a snapshot of the count. Completion of a command is reported with a one-cycle acknowledge.

Top module: `updn_timer`

## Requirements
- R1: After reset the count is 0, the active and buffered period are all ones, the active and buffered compare values are 0, the counter is running, and ovf, unf, cmd_ack, cmd_busy and count_snap are 0.
- R2: The count changes only on a tick while the counter is running. With dir=0 it increments and with dir=1 it decrements.
- R3: Counting up, a tick with count greater than or equal to the active period loads 0 and makes ovf high for exactly the following cycle.
- R4: Counting down, a tick with count 0 loads the active period as it stands after that tick's update (the new value if buffers are copied on that tick) and makes unf high for the following cycle.
- R5: With oneshot high, the wrap of R3 or R4 still loads its reload value and also sets stopped. The count then holds until a restart command is carried out.
- R6: At every wrap, the period and compare buffers are copied into the active registers when lock_upd is low or capture_en is high. When lock_upd is high and capture_en is low, the active registers keep their values.
- R7: A cycle with cmd_valid high and a nonzero cmd code stores that code as pending, replacing any older pending code. Code 0 is ignored. cmd_busy shows that a code is pending. The pending code runs at the first tick after the write cycle: it is then cleared, and cmd_ack is high for the next cycle. Codes 5 to 7 are acknowledged and do nothing else.
- R8: Code 1 (restart) loads 0 when dir=0 and the active period when dir=1, clears stopped, and raises no wrap flag on that tick.
- R9: Code 2 (halt) sets stopped and leaves the count unchanged.
- R10: Code 3 (forced update) copies every buffer into its active register, whatever the level of lock_upd.
- R11: Code 4 (read sync) loads count_snap with the count as it stood just before the tick that runs the command.
- R12: A buffer write port updates only its buffer. The active value stays unchanged until a copy happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| dir | input | 1 | 0 count up, 1 count down |
| oneshot | input | 1 | Halt at next wrap |
| lock_upd | input | 1 | Block the copy to active registers at a wrap |
| capture_en | input | 1 | Capture mode active, overrides lock_upd |
| cmd_valid | input | 1 | Command write strobe |
| cmd | input | 3 | Command code |
| per_buf_we | input | 1 | Period buffer write |
| per_buf_wdata | input | CNT_W | Period buffer data |
| cc_buf_we | input | NUM_CC | Per-channel compare buffer write |
| cc_buf_wdata | input | CNT_W | Compare buffer data shared by channels |
| count | output | CNT_W | Current count |
| count_snap | output | CNT_W | Count captured by read sync |
| per_act | output | CNT_W | Active period |
| cc_act | output | NUM_CC*CNT_W | Active compare values, channel 0 in the low bits |
| ovf | output | 1 | Overflow pulse |
| unf | output | 1 | Underflow pulse |
| stopped | output | 1 | Counter halted |
| cmd_busy | output | 1 | A command is pending |
| cmd_ack | output | 1 | Command carried out, one-cycle pulse |

## Verification
The count, count_snap, ovf, unf, stopped and the active registers all change at the rising edge that samples tick high, so each of them is due one edge after the stimulus. cmd_busy is due one edge after the write cycle. A command runs at the first tick edge after its write, and cmd_ack rises at that same edge. The bench drives its inputs at the falling edge, steps its own model at the rising edge, and compares every output at the next falling edge. Each result is therefore checked exactly one edge after the cycle that caused it.

// File: rtl/utmr_pkg.sv
package utmr_pkg;

  typedef enum logic [2:0] {
    TCMD_NONE   = 3'd0,
    TCMD_RETRIG = 3'd1,
    TCMD_HALT   = 3'd2,
    TCMD_UPDATE = 3'd3,
    TCMD_RDSYNC = 3'd4
  } tcmd_e;

  typedef struct packed {
    logic retrig;
    logic halt;
    logic force_upd;
    logic rd_sync;
  } cmd_strb_t;

endpackage

// File: rtl/utmr_cmd_seq.sv
module utmr_cmd_seq
  import utmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  logic [2:0] cmd,
  output cmd_strb_t  strb,
  output logic       busy,
  output logic       ack
);

  tcmd_e pend_q;
  logic  ack_q;
  logic  exec;
  logic  wr_hit;

  function automatic cmd_strb_t decode_cmd(input tcmd_e c, input logic fire);
    cmd_strb_t s;
    s = '0;
    if (fire) begin
      case (c)
        TCMD_RETRIG: s.retrig    = 1'b1;
        TCMD_HALT:   s.halt      = 1'b1;
        TCMD_UPDATE: s.force_upd = 1'b1;
        TCMD_RDSYNC: s.rd_sync   = 1'b1;
        default:     s           = '0;
      endcase
    end
    return s;
  endfunction

  assign wr_hit = cmd_valid && (cmd != 3'd0);
  assign exec   = tick && (pend_q != TCMD_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= TCMD_NONE;
      ack_q  <= 1'b0;
    end else begin
      if (wr_hit)    pend_q <= tcmd_e'(cmd);
      else if (exec) pend_q <= TCMD_NONE;
      ack_q <= exec;
    end
  end

  assign strb = decode_cmd(pend_q, exec);
  assign busy = (pend_q != TCMD_NONE);
  assign ack  = ack_q;

endmodule

// File: rtl/utmr_buf_bank.sv
module utmr_buf_bank #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_CC   = 2,
  parameter logic [CNT_W-1:0] PER_INIT = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    per_we,
  input  logic [CNT_W-1:0]        per_wdata,
  input  logic [NUM_CC-1:0]       cc_we,
  input  logic [CNT_W-1:0]        cc_wdata,
  input  logic                    copy_en,
  output logic [CNT_W-1:0]        per_buf,
  output logic [CNT_W-1:0]        per_act,
  output logic [NUM_CC*CNT_W-1:0] cc_act
);

  logic [CNT_W-1:0] per_buf_q;
  logic [CNT_W-1:0] per_act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_buf_q <= PER_INIT;
      per_act_q <= PER_INIT;
    end else begin
      if (per_we)  per_buf_q <= per_wdata;
      if (copy_en) per_act_q <= per_buf_q;
    end
  end

  assign per_buf = per_buf_q;
  assign per_act = per_act_q;

  for (genvar g = 0; g < NUM_CC; g++) begin : g_ch
    logic [CNT_W-1:0] buf_q;
    logic [CNT_W-1:0] act_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_q <= '0;
        act_q <= '0;
      end else begin
        if (cc_we[g]) buf_q <= cc_wdata;
        if (copy_en)  act_q <= buf_q;
      end
    end

    assign cc_act[g*CNT_W +: CNT_W] = act_q;
  end

endmodule

// File: rtl/utmr_counter.sv
module utmr_counter
  import utmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dir,
  input  logic             oneshot,
  input  logic             lock_upd,
  input  logic             capture_en,
  input  cmd_strb_t        strb,
  input  logic [CNT_W-1:0] per_act,
  input  logic [CNT_W-1:0] per_buf,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_snap,
  output logic             ovf,
  output logic             unf,
  output logic             stopped,
  output logic             wrap_evt,
  output logic             copy_en
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] snap_q;
  logic             stop_q;
  logic             ovf_q;
  logic             unf_q;
  logic             run_tick;
  logic             wrap_up;
  logic             wrap_dn;
  logic [CNT_W-1:0] per_next;

  function automatic logic hit_top(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return c >= p;
  endfunction

  function automatic logic [CNT_W-1:0] step_cnt(input logic [CNT_W-1:0] c, input logic down);
    return down ? c - CNT_W'(1) : c + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] restart_val(input logic down, input logic [CNT_W-1:0] p);
    return down ? p : '0;
  endfunction

  assign run_tick = tick && !stop_q && !strb.retrig && !strb.halt;
  assign wrap_up  = run_tick && !dir && hit_top(cnt_q, per_act);
  assign wrap_dn  = run_tick &&  dir && (cnt_q == '0);
  assign wrap_evt = wrap_up || wrap_dn;
  assign copy_en  = strb.force_upd || (wrap_evt && (!lock_upd || capture_en));
  assign per_next = copy_en ? per_buf : per_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
      stop_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (strb.retrig)  cnt_q <= restart_val(dir, per_next);
      else if (wrap_up) cnt_q <= '0;
      else if (wrap_dn) cnt_q <= per_next;
      else if (run_tick) cnt_q <= step_cnt(cnt_q, dir);

      if (strb.retrig)                stop_q <= 1'b0;
      else if (strb.halt)             stop_q <= 1'b1;
      else if (wrap_evt && oneshot)   stop_q <= 1'b1;

      if (strb.rd_sync) snap_q <= cnt_q;

      ovf_q <= wrap_up;
      unf_q <= wrap_dn;
    end
  end

  assign count      = cnt_q;
  assign count_snap = snap_q;
  assign ovf        = ovf_q;
  assign unf        = unf_q;
  assign stopped    = stop_q;

endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import utmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_CC   = 2,
  parameter logic [CNT_W-1:0] PER_INIT = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    dir,
  input  logic                    oneshot,
  input  logic                    lock_upd,
  input  logic                    capture_en,
  input  logic                    cmd_valid,
  input  logic [2:0]              cmd,
  input  logic                    per_buf_we,
  input  logic [CNT_W-1:0]        per_buf_wdata,
  input  logic [NUM_CC-1:0]       cc_buf_we,
  input  logic [CNT_W-1:0]        cc_buf_wdata,
  output logic [CNT_W-1:0]        count,
  output logic [CNT_W-1:0]        count_snap,
  output logic [CNT_W-1:0]        per_act,
  output logic [NUM_CC*CNT_W-1:0] cc_act,
  output logic                    ovf,
  output logic                    unf,
  output logic                    stopped,
  output logic                    cmd_busy,
  output logic                    cmd_ack
);

  cmd_strb_t        strb;
  logic [CNT_W-1:0] per_buf;
  logic             copy_evt;
  logic             wrap_evt;
  logic             force_upd_evt;
  logic             retrig_evt;
  logic             halt_evt;

  assign force_upd_evt = strb.force_upd;
  assign retrig_evt    = strb.retrig;
  assign halt_evt      = strb.halt;

  utmr_cmd_seq u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .strb      (strb),
    .busy      (cmd_busy),
    .ack       (cmd_ack)
  );

  utmr_buf_bank #(
    .CNT_W    (CNT_W),
    .NUM_CC   (NUM_CC),
    .PER_INIT (PER_INIT)
  ) u_bufs (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_we    (per_buf_we),
    .per_wdata (per_buf_wdata),
    .cc_we     (cc_buf_we),
    .cc_wdata  (cc_buf_wdata),
    .copy_en   (copy_evt),
    .per_buf   (per_buf),
    .per_act   (per_act),
    .cc_act    (cc_act)
  );

  utmr_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .dir        (dir),
    .oneshot    (oneshot),
    .lock_upd   (lock_upd),
    .capture_en (capture_en),
    .strb       (strb),
    .per_act    (per_act),
    .per_buf    (per_buf),
    .count      (count),
    .count_snap (count_snap),
    .ovf        (ovf),
    .unf        (unf),
    .stopped    (stopped),
    .wrap_evt   (wrap_evt),
    .copy_en    (copy_evt)
  );

endmodule

// File: rtl/utmr_checker.sv
module utmr_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             oneshot,
  input logic             lock_upd,
  input logic             capture_en,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] per_act,
  input logic             ovf,
  input logic             unf,
  input logic             stopped,
  input logic             cmd_ack,
  input logic             wrap_evt,
  input logic             force_upd_evt,
  input logic             retrig_evt,
  input logic             halt_evt
);

  AST_NO_COUNT_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(count)); // R2

  AST_OVF_LOADS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0)); // R3

  AST_UNF_LOADS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (count == per_act)); // R4

  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && oneshot) |=> stopped); // R5

  AST_LOCK_HOLDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && lock_upd && !capture_en && !force_upd_evt) |=> $stable(per_act)); // R6

  AST_ACK_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> $past(tick)); // R7

  AST_RETRIG_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    retrig_evt |=> !stopped); // R8

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> stopped); // R9

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stopped) && stopped) |-> $stable(count)); // R9

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf)); // R3

endmodule

bind updn_timer utmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .oneshot       (oneshot),
  .lock_upd      (lock_upd),
  .capture_en    (capture_en),
  .count         (count),
  .per_act       (per_act),
  .ovf           (ovf),
  .unf           (unf),
  .stopped       (stopped),
  .cmd_ack       (cmd_ack),
  .wrap_evt      (wrap_evt),
  .force_upd_evt (force_upd_evt),
  .retrig_evt    (retrig_evt),
  .halt_evt      (halt_evt)
);

// File: tb/updn_timer_bench.sv
module updn_timer_bench;

  localparam int unsigned CNT_W  = 16;
  localparam int unsigned NUM_CC = 2;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    tick = 1'b0, dir = 1'b0, oneshot = 1'b0;
  logic                    lock_upd = 1'b0, capture_en = 1'b0;
  logic                    cmd_valid = 1'b0;
  logic [2:0]              cmd = 3'd0;
  logic                    per_buf_we = 1'b0;
  logic [CNT_W-1:0]        per_buf_wdata = '0;
  logic [NUM_CC-1:0]       cc_buf_we = '0;
  logic [CNT_W-1:0]        cc_buf_wdata = '0;
  logic [CNT_W-1:0]        count, count_snap, per_act;
  logic [NUM_CC*CNT_W-1:0] cc_act;
  logic                    ovf, unf, stopped, cmd_busy, cmd_ack;

  int checks = 0;
  int errors = 0;
  int ovf_seen = 0;
  int unf_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  updn_timer #(.CNT_W(CNT_W), .NUM_CC(NUM_CC)) u_updn_timer (.*);

  // reference model state
  logic [CNT_W-1:0] m_cnt, m_per, m_pbuf, m_snap;
  logic [CNT_W-1:0] m_cc [NUM_CC];
  logic [CNT_W-1:0] m_cbuf [NUM_CC];
  logic             m_stop, m_ack, m_ovf, m_unf;
  int               m_pend;

  function automatic logic [CNT_W-1:0] ref_reload(input logic down, input logic [CNT_W-1:0] p);
    if (down) return p;
    return '0;
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_per = '1; m_pbuf = '1; m_snap = '0;
    for (int i = 0; i < NUM_CC; i++) begin m_cc[i] = '0; m_cbuf[i] = '0; end
    m_stop = 0; m_ack = 0; m_ovf = 0; m_unf = 0; m_pend = 0;
  endtask

  task automatic model_step();
    bit fire, rt, hl, fu, rs, go, upw, dnw, cp;
    logic [CNT_W-1:0] nper;
    fire = tick && (m_pend != 0);
    rt = fire && m_pend == 1;
    hl = fire && m_pend == 2;
    fu = fire && m_pend == 3;
    rs = fire && m_pend == 4;
    go  = tick && !m_stop && !rt && !hl;
    upw = go && !dir && (m_cnt >= m_per);
    dnw = go && dir && (m_cnt == 0);
    cp  = fu || ((upw || dnw) && (capture_en || !lock_upd));
    nper = cp ? m_pbuf : m_per;
    if (rs) m_snap = m_cnt;
    if (rt) m_cnt = ref_reload(dir, nper);
    else if (upw) m_cnt = '0;
    else if (dnw) m_cnt = nper;
    else if (go) m_cnt = dir ? m_cnt - 1'b1 : m_cnt + 1'b1;
    if (rt) m_stop = 0;
    else if (hl || ((upw || dnw) && oneshot)) m_stop = 1;
    if (cp) begin
      m_per = m_pbuf;
      for (int i = 0; i < NUM_CC; i++) m_cc[i] = m_cbuf[i];
    end
    if (per_buf_we) m_pbuf = per_buf_wdata;
    for (int i = 0; i < NUM_CC; i++) if (cc_buf_we[i]) m_cbuf[i] = cc_buf_wdata;
    if (cmd_valid && cmd != 3'd0) m_pend = int'(cmd);
    else if (fire) m_pend = 0;
    m_ack = fire; m_ovf = upw; m_unf = dnw;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 count", 32'(count), 32'(m_cnt));
    chk("R3 ovf", 32'(ovf), 32'(m_ovf));
    chk("R4 unf", 32'(unf), 32'(m_unf));
    chk("R5 stopped", 32'(stopped), 32'(m_stop));
    chk("R6 per_act", 32'(per_act), 32'(m_per));
    for (int i = 0; i < NUM_CC; i++)
      chk("R6 cc_act", 32'(cc_act[i*CNT_W +: CNT_W]), 32'(m_cc[i]));
    chk("R7 cmd_ack", 32'(cmd_ack), 32'(m_ack));
    chk("R7 cmd_busy", 32'(cmd_busy), 32'(m_pend != 0));
    chk("R11 count_snap", 32'(count_snap), 32'(m_snap));
    if (ovf) ovf_seen++;
    if (unf) unf_seen++;
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    if (rst_n) check_all();
    cmd_valid = 0; per_buf_we = 0; cc_buf_we = '0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic send(input logic [2:0] c);
    cmd_valid = 1; cmd = c;
  endtask

  initial begin
    logic [CNT_W-1:0] held;
    void'($urandom(32'd4242));
    model_reset();
    run(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 per_act", 32'(per_act), 32'hFFFF);
    chk("R1 cc_act", 32'(cc_act), 0);
    chk("R1 flags", {28'd0, ovf, unf, cmd_ack, cmd_busy}, 0);
    chk("R1 stopped", 32'(stopped), 0);
    chk("R1 snap", 32'(count_snap), 0);

    // R12 buffer write leaves active untouched
    per_buf_we = 1; per_buf_wdata = 16'd5; cc_buf_we = 2'b11; cc_buf_wdata = 16'd3;
    cyc();
    chk("R12 per_act held", 32'(per_act), 32'hFFFF);
    chk("R12 cc_act held", 32'(cc_act), 0);

    // R7 pending waits for tick, R10 forced update ignores lock
    lock_upd = 1; send(3'd3);
    cyc();
    chk("R7 busy after write", 32'(cmd_busy), 1);
    cyc();
    chk("R7 waits for tick", 32'(per_act), 32'hFFFF);
    tick = 1;
    cyc();
    chk("R10 forced copy", 32'(per_act), 5);
    chk("R10 forced cc", 32'(cc_act), 32'h0003_0003);
    chk("R7 ack", 32'(cmd_ack), 1);

    run(12);
    per_buf_we = 1; per_buf_wdata = 16'd9;
    run(12);
    chk("R6 locked", 32'(per_act), 5);
    capture_en = 1;
    run(8);
    chk("R6 capture overrides lock", 32'(per_act), 9);
    capture_en = 0; lock_upd = 0;
    chk("R3 overflow seen", 32'(ovf_seen > 0), 1);

    dir = 1;
    run(25);
    chk("R4 underflow seen", 32'(unf_seen > 0), 1);

    oneshot = 1;
    run(25);
    chk("R5 halted", 32'(stopped), 1);
    held = count;
    run(3);
    chk("R5 holds", 32'(count), 32'(held));
    oneshot = 0;

    send(3'd1); cyc(); cyc();
    chk("R8 restart running", 32'(stopped), 0);
    chk("R8 restart down loads period", 32'(count), 9);

    send(3'd2); cyc(); cyc();
    chk("R9 halt", 32'(stopped), 1);
    held = count;
    run(2);
    chk("R9 count held", 32'(count), 32'(held));

    dir = 0;
    send(3'd1); cyc(); cyc();
    chk("R8 restart up loads zero", 32'(count), 0);
    run(3);
    send(3'd4); cyc();
    held = count;
    cyc();
    chk("R11 snapshot", 32'(count_snap), 32'(held));

    send(3'd0); cyc();
    chk("R7 zero ignored busy", 32'(cmd_busy), 0);
    cyc();
    chk("R7 zero ignored ack", 32'(cmd_ack), 0);

    // constrained random phase
    for (int k = 0; k < 4000; k++) begin
      tick = ($urandom % 2) == 0;
      if ($urandom % 64 == 0) dir = ~dir;
      if ($urandom % 32 == 0) oneshot = ~oneshot;
      lock_upd = $urandom % 2;
      capture_en = ($urandom % 8) == 0;
      if ($urandom % 10 == 0) send(3'($urandom % 8));
      if ($urandom % 12 == 0) begin
        per_buf_we = 1; per_buf_wdata = 16'(2 + $urandom % 23);
      end
      if ($urandom % 12 == 0) begin
        cc_buf_we = 2'($urandom % 4); cc_buf_wdata = 16'($urandom);
      end
      cyc();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule